// File: doc/BRIEF.md
# Character Cell Fetch Sequencer

This block paces a text-mode video pipeline one character cell at a time. A three-bit pixel counter advances on each pixel strobe and wraps after six or eight pixels, depending on the selected cell width. Within each cell the counter is decoded into a fixed sequence of memory strobes. First comes a screen-memory fetch, which reads the character code through its own buffer. Then comes a character-generator fetch, which reads the glyph row through a second buffer. On the last pixel the output shift register is loaded.

A processor phase clock, PHI, is derived from the same counter. It is high only in the slots where no video fetch happens, so a processor that shares the memory always accesses it in the opposite phase to the video. The address-generating controller never signals individual characters. It only raises a start request at the beginning of the active part of a line and a stop request at its end. Both requests may arrive asynchronously. Each is synchronized, edge-detected, and applied at the next cell boundary. Between those two points the sequencer paces every cell on its own.

Top module: `cell_fetch_seq`

## Requirements
- R1: While reset is asserted, and until the first pixel strobe after the reset is released, all outputs are low, including phi. Reset leaves the cell counter at 0, the active flag clear and the cell width at six pixels.
- R2: The cell counter advances by one only in a cycle where pix_en is high. With pix_en low, every output holds its value.
- R3: With width 6 (wide_sel = 0) the counter wraps from 5 to 0. With width 8 (wide_sel = 1) it wraps from 7 to 0. wide_sel is sampled only on the wrapping strobe and applies to the following cell. The first cell after reset is six pixels wide.
- R4: While active, the screen fetch occupies counts 0 and 1. mem_ce and scan_buf are high in both counts, and mem_rd is high in count 1.
- R5: While active, the character-generator fetch occupies counts 2 and 3. mem_ce and cgen_buf are high in both counts, and mem_rd is high in count 3. scan_buf and cgen_buf are never high together.
- R6: While active, shift_load is high only in the last count of the cell (5 or 7).
- R7: phi is high in counts 4 and above and low in counts 0 to 3, whether or not the sequencer is active. It is never high together with mem_ce.
- R8: A rising edge on start_req arms the request and a rising edge on stop_req disarms it; stop wins if both arrive together. Each edge is seen after a two-flop synchronizer plus an edge register. The active flag copies the armed state only on the wrapping pixel strobe.
- R9: While the active flag is clear, mem_ce, mem_rd, scan_buf, cgen_buf and shift_load stay low, and the counter and phi keep running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pix_en | input | 1 | Pixel strobe, one count per high cycle |
| wide_sel | input | 1 | Cell width select: 0 six pixels, 1 eight pixels |
| start_req | input | 1 | Asynchronous start request from the controller, rising edge |
| stop_req | input | 1 | Asynchronous stop request from the controller, rising edge |
| mem_ce | output | 1 | Memory chip enable during either video fetch |
| mem_rd | output | 1 | Memory read strobe, second count of each fetch |
| scan_buf | output | 1 | Buffer select for the screen-memory fetch |
| cgen_buf | output | 1 | Buffer select for the character-generator fetch |
| shift_load | output | 1 | Load pulse for the pixel shift register |
| phi | output | 1 | Processor phase clock, high in the processor window |

## Verification
Several properties are checked on every cycle:
- phi and mem_ce never overlap.
- The two buffer selects are mutually exclusive.
- mem_rd only occurs inside a fetch.
- The counter stays below the wrap point of the latched width.
- The active flag and the latched width change only on a wrapping strobe.
- No strobe leaves the block while it is idle.

Only the bench scenarios can show the rest. These are the exact cell length after a width change, the latency of the synchronized start and stop edges, and stop winning over a simultaneous start. They also cover holding state under a sparse pixel strobe and a clean restart after a mid-run reset, all compared against a cycle model.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  typedef enum logic {
    CELL_NARROW = 1'b0,
    CELL_WIDE   = 1'b1
  } cell_w_e;

  typedef struct packed {
    logic mem_ce;
    logic mem_rd;
    logic scan_buf;
    logic cgen_buf;
    logic shift_load;
    logic phi;
  } fetch_out_t;
endpackage

// File: rtl/cfs_rst_sync.sv
module cfs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cfs_req_sync.sv
module cfs_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_in,
  output logic rise
);
  // STAGES synchronizer flops plus one edge-history flop
  logic [STAGES:0] pipe_q;
  logic [STAGES:0] pipe_d;

  always_comb pipe_d = {pipe_q[STAGES-1:0], req_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/cfs_cell_ctr.sv
module cfs_cell_ctr
  import cfs_pkg::*;
#(
  parameter int CNT_W  = 3,
  parameter int NARROW = 6,
  parameter int WIDE   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_en,
  input  logic             wide_sel,
  input  logic             start_rise,
  input  logic             stop_rise,
  output logic [CNT_W-1:0] cnt,
  output logic             last,
  output logic             active
);
  localparam logic [CNT_W-1:0] LAST_N = CNT_W'(NARROW - 1);
  localparam logic [CNT_W-1:0] LAST_W = CNT_W'(WIDE - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  cell_w_e          wid_q, wid_d;
  logic             arm_q, arm_d;
  logic             act_q, act_d;
  logic             bnd;

  assign last = (cnt_q == ((wid_q == CELL_WIDE) ? LAST_W : LAST_N));
  assign bnd  = pix_en & last;

  always_comb begin
    cnt_d = cnt_q;
    wid_d = wid_q;
    act_d = act_q;
    arm_d = arm_q;
    if (bnd) begin
      cnt_d = '0;
      wid_d = cell_w_e'(wide_sel);
      act_d = arm_q;
    end else if (pix_en) begin
      cnt_d = cnt_q + 1'b1;
    end
    if (stop_rise)       arm_d = 1'b0;
    else if (start_rise) arm_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      wid_q <= CELL_NARROW;
      arm_q <= 1'b0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      wid_q <= wid_d;
      arm_q <= arm_d;
      act_q <= act_d;
    end
  end

  assign cnt    = cnt_q;
  assign active = act_q;

  a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ((wid_q == CELL_WIDE) ? LAST_W : LAST_N));
  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bnd |=> (cnt_q == '0));
  a_r3_width_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wid_q) |-> $past(bnd));
  a_r2_hold_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(cnt_q));
  a_r8_active_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> $past(bnd));
endmodule

// File: rtl/cfs_fetch_dec.sv
module cfs_fetch_dec
  import cfs_pkg::*;
#(
  parameter int CNT_W = 3,
  parameter int SLOT  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             last,
  input  logic             active,
  output fetch_out_t       outs
);
  localparam logic [CNT_W-1:0] SCAN_END = CNT_W'(SLOT);
  localparam logic [CNT_W-1:0] CGEN_END = CNT_W'(2 * SLOT);
  localparam logic [CNT_W-1:0] SCAN_RD  = CNT_W'(SLOT - 1);
  localparam logic [CNT_W-1:0] CGEN_RD  = CNT_W'(2 * SLOT - 1);

  logic in_scan, in_cgen;

  always_comb begin
    in_scan         = (cnt < SCAN_END);
    in_cgen         = (cnt >= SCAN_END) && (cnt < CGEN_END);
    outs.scan_buf   = active & in_scan;
    outs.cgen_buf   = active & in_cgen;
    outs.mem_ce     = active & (in_scan | in_cgen);
    outs.mem_rd     = active & ((cnt == SCAN_RD) | (cnt == CGEN_RD));
    outs.shift_load = active & last;
    outs.phi        = (cnt >= CGEN_END);
  end

  a_r7_phi_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(outs.phi && outs.mem_ce));
  a_r5_buf_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({outs.scan_buf, outs.cgen_buf}));
  a_r4_rd_in_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    outs.mem_rd |-> outs.mem_ce);
  a_r6_load_outside_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    outs.shift_load |-> (outs.phi && !outs.mem_ce));
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !(outs.mem_ce || outs.mem_rd || outs.shift_load));
endmodule

// File: rtl/cell_fetch_seq.sv
module cell_fetch_seq
  import cfs_pkg::*;
#(
  parameter int CNT_W      = 3,
  parameter int NARROW     = 6,
  parameter int WIDE       = 8,
  parameter int SLOT       = 2,
  parameter int SYNC_FLOPS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pix_en,
  input  logic wide_sel,
  input  logic start_req,
  input  logic stop_req,
  output logic mem_ce,
  output logic mem_rd,
  output logic scan_buf,
  output logic cgen_buf,
  output logic shift_load,
  output logic phi
);
  logic             rst_i_n;
  logic             start_rise, stop_rise;
  logic [CNT_W-1:0] cnt;
  logic             last, active;
  fetch_out_t       outs;

  cfs_rst_sync #(.STAGES(SYNC_FLOPS)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  cfs_req_sync #(.STAGES(SYNC_FLOPS)) u_start (
    .clk(clk), .rst_n(rst_i_n), .req_in(start_req), .rise(start_rise));

  cfs_req_sync #(.STAGES(SYNC_FLOPS)) u_stop (
    .clk(clk), .rst_n(rst_i_n), .req_in(stop_req), .rise(stop_rise));

  cfs_cell_ctr #(.CNT_W(CNT_W), .NARROW(NARROW), .WIDE(WIDE)) u_ctr (
    .clk(clk), .rst_n(rst_i_n), .pix_en(pix_en), .wide_sel(wide_sel),
    .start_rise(start_rise), .stop_rise(stop_rise),
    .cnt(cnt), .last(last), .active(active));

  cfs_fetch_dec #(.CNT_W(CNT_W), .SLOT(SLOT)) u_dec (
    .clk(clk), .rst_n(rst_i_n), .cnt(cnt), .last(last),
    .active(active), .outs(outs));

  assign mem_ce     = outs.mem_ce;
  assign mem_rd     = outs.mem_rd;
  assign scan_buf   = outs.scan_buf;
  assign cgen_buf   = outs.cgen_buf;
  assign shift_load = outs.shift_load;
  assign phi        = outs.phi;
endmodule

// File: tb/cell_fetch_seq_tb.sv
module cell_fetch_seq_tb;
  logic clk = 1'b0;
  logic rst_n, pix_en, wide_sel, start_req, stop_req;
  logic mem_ce, mem_rd, scan_buf, cgen_buf, shift_load, phi;
  int   n_chk = 0, n_fail = 0;
  bit   done = 0, cmp_on = 0;

  always #5 clk = ~clk;

  cell_fetch_seq u_dut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .wide_sel(wide_sel),
    .start_req(start_req), .stop_req(stop_req), .mem_ce(mem_ce),
    .mem_rd(mem_rd), .scan_buf(scan_buf), .cgen_buf(cgen_buf),
    .shift_load(shift_load), .phi(phi));

  // behavioural cycle model
  bit m_r1, m_r2, sa1, sa2, sa3, sp1, sp2, sp3, m_arm, m_act, m_wid;
  int m_cnt;

  task automatic m_clear();
    sa1 = 0; sa2 = 0; sa3 = 0; sp1 = 0; sp2 = 0; sp3 = 0;
    m_arm = 0; m_act = 0; m_wid = 0; m_cnt = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_r1 = 0; m_r2 = 0; m_clear();
    end else begin
      if (!m_r2) m_clear();
      else begin
        int  lim;
        bit  ra, rp;
        lim = m_wid ? 8 : 6;
        ra  = sa2 && !sa3;
        rp  = sp2 && !sp3;
        if (pix_en && m_cnt == lim - 1) begin
          m_act = m_arm; m_wid = wide_sel; m_cnt = 0;
        end else if (pix_en) m_cnt++;
        if (rp) m_arm = 0; else if (ra) m_arm = 1;
        sa3 = sa2; sa2 = sa1; sa1 = start_req;
        sp3 = sp2; sp2 = sp1; sp1 = stop_req;
      end
      m_r2 = m_r1; m_r1 = 1;
    end
  end

  task automatic chk(string req, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    int lim;
    lim = m_wid ? 8 : 6;
    chk("R4 R8 R9", mem_ce,   m_act && m_cnt < 4, "mem_ce");
    chk("R4 R5",    mem_rd,   m_act && (m_cnt == 1 || m_cnt == 3), "mem_rd");
    chk("R4",       scan_buf, m_act && m_cnt < 2, "scan_buf");
    chk("R5",       cgen_buf, m_act && m_cnt >= 2 && m_cnt < 4, "cgen_buf");
    chk("R6 R3",    shift_load, m_act && m_cnt == lim - 1, "shift_load");
    chk("R7 R2",    phi,      m_cnt >= 4, "phi");
  end

  task automatic pulse(bit st, bit sp);
    @(negedge clk); start_req = st; stop_req = sp;
    repeat (3) @(negedge clk);
    start_req = 0; stop_req = 0;
  endtask

  task automatic measure(int exp);
    int n = 0, guard = 0;
    while (!shift_load && guard < 100) begin @(negedge clk); guard++; end
    do begin @(negedge clk); n++; end while (!shift_load && n < 100);
    chk("R3", n == exp, 1'b1, $sformatf("cell length %0d vs %0d", n, exp));
  endtask

  task automatic all_low(string req);
    chk(req, mem_ce | mem_rd | scan_buf | cgen_buf | shift_load | phi, 1'b0, "any output");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] lf;
    rst_n = 0; pix_en = 0; wide_sel = 0; start_req = 0; stop_req = 0;
    repeat (3) @(negedge clk);
    all_low("R1");
    rst_n = 1; cmp_on = 1;
    repeat (4) @(negedge clk);
    all_low("R1");
    // idle run: phi runs, no video strobes
    pix_en = 1;
    repeat (20) @(negedge clk);
    // start, six-wide cells
    pulse(1, 0);
    repeat (30) @(negedge clk);
    measure(6);
    measure(6);
    // width change, applied at next wrap
    wide_sel = 1;
    repeat (20) @(negedge clk);
    measure(8);
    // R2: hold with no strobe
    pix_en = 0;
    begin
      logic [5:0] snap;
      @(negedge clk);
      snap = {mem_ce, mem_rd, scan_buf, cgen_buf, shift_load, phi};
      repeat (6) begin
        @(negedge clk);
        chk("R2", {mem_ce, mem_rd, scan_buf, cgen_buf, shift_load, phi} == snap, 1'b1, "hold");
      end
    end
    // sparse strobe with width toggles
    lf = 8'h5a;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      pix_en = lf[0] | lf[2];
      if (i % 37 == 0) wide_sel = lf[1];
    end
    pix_en = 1;
    // stop, then idle must stay quiet while phi keeps toggling
    pulse(0, 1);
    repeat (20) @(negedge clk);
    begin
      int phi_hi = 0;
      repeat (16) begin
        @(negedge clk);
        chk("R9", mem_ce | shift_load, 1'b0, "idle strobe");
        if (phi) phi_hi++;
      end
      chk("R7 R9", phi_hi > 0, 1'b1, "phi runs while idle");
    end
    // simultaneous start and stop: stop wins
    pulse(1, 1);
    repeat (24) @(negedge clk);
    chk("R8", mem_ce, 1'b0, "stop wins");
    // restart then mid-run reset
    pulse(1, 0);
    repeat (25) @(negedge clk);
    rst_n = 0; cmp_on = 0;
    @(negedge clk);
    all_low("R1");
    rst_n = 1; cmp_on = 1;
    repeat (30) @(negedge clk);
    chk("R1", mem_ce, 1'b0, "inactive after reset");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule